// File: doc/BRIEF.md
# Capture/Compare Timer

A 24-bit up-counter drives four channels. Each channel works either as a capture register or as a compare register. The counter advances by one on each count tick. A tick is either a pulse on an internal count-enable input or a rising edge of an asynchronous external event input. A run bit gates the counting, and a source bit picks between the two tick sources. With these the block serves as an interval timer, a free-running timer or an event counter.

A channel in capture mode copies the current count when its trigger input shows a selected edge. The trigger is synchronised first, and the edge can be rising, falling or both. The copied value stays until the next capture. A channel in compare mode checks its register against the count on every tick. On a match it sets or clears its own output flop, as configured, and pulses a match strobe for one cycle.

A small register port handles writes and combinational reads. Each read gives either a 32-bit view or a 16-bit view.

Top module: `capcmp_timer`

## Requirements
- R1: After reset, the counter, both control registers, all channel registers, the outputs, the match strobes and the overflow strobe are all zero.
- R2: Control word at address 0 holds run in bit 0. While run is 1, each tick adds one to the counter. While run is 0, the counter holds its value.
- R3: Bit 1 of address 0 selects the tick source. Value 0 selects tick_int high in a cycle. Value 1 selects a rising edge of evt_in after two synchroniser flops. The source that is not selected has no effect.
- R4: A read with rd_half=0 returns the value zero-extended to 32 bits, so bits 31..24 read zero. A read with rd_half=1 returns only bits 15..0, and bits 31..16 read zero. Address map: 0 = run/source, 1 = channel config, 2 = counter, 4+n = channel n.
- R5: The channel config at address 1 uses 4 bits per channel, placed at bits 4n+3..4n. Bit 4n=0 selects capture mode. In capture mode, an edge on the synchronised trig_in[n] copies the count of that cycle into channel n. Bits 4n+2..4n+1 select the edge: 01 rising, 10 falling, 11 both, 00 none. The register holds its value between captures.
- R6: A write to address 4+n stores wr_data[23..0] only when channel n is in compare mode (bit 4n=1). Bits 31..24 are dropped. A write to a channel in capture mode is ignored.
- R7: In compare mode, a tick whose pre-increment count equals the channel register updates cmp_out[n] on the next clock. The output becomes 1 when bit 4n+3 is 1 and 0 when that bit is 0.
- R8: match_pulse[n] is high for exactly the cycle in which that compare update takes effect.
- R9: A tick taken at count 0xFFFFFF wraps the counter to 0. ovf_pulse is high for the following cycle.
- R10: A write to address 2 loads the counter from wr_data[23..0]. The load takes priority over a tick in the same cycle, and it raises no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_int | input | 1 | Internal count enable |
| evt_in | input | 1 | Asynchronous external count input |
| trig_in | input | 4 | Asynchronous capture triggers, one per channel |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read address |
| rd_half | input | 1 | 1 selects the 16-bit read view |
| rd_data | output | 32 | Combinational read data |
| cmp_out | output | 4 | Per-channel set/reset outputs |
| match_pulse | output | 4 | One-cycle compare match strobes |
| ovf_pulse | output | 1 | One-cycle counter wrap strobe |

## Verification
A wrong count or a lost tick shows on the next read of address 2. It also moves every later compare match, so cmp_out and match_pulse depart from the model in the cycle that should have matched. A wrong synchroniser depth or edge polarity gives captured values that differ by the ticks of one or more cycles. This shows at the first read of that channel after the trigger. A capture or write that lands in the wrong mode corrupts the channel register, and the next read of that address shows it. The bench compares all outputs and the addressed register against a reference on every clock, so a fault shows within one cycle of becoming observable.

// File: rtl/capcmp_pkg.sv
package capcmp_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTL0 = 3'd0;
    localparam logic [ADDR_W-1:0] A_CTL1 = 3'd1;
    localparam logic [ADDR_W-1:0] A_CNT  = 3'd2;
    localparam logic [ADDR_W-1:0] A_CH0  = 3'd4;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;

    // bit 3: output action on match, bits 2:1: edge select, bit 0: compare mode
    typedef struct packed {
        logic      act_set;
        edge_sel_e edg;
        logic      is_cmp;
    } ch_cfg_t;
endpackage

// File: rtl/capcmp_sync_edge.sv
module capcmp_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] sh_q, sh_d;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
    assign fall = ~sh_q[STAGES-1] & sh_q[STAGES];
endmodule

// File: rtl/capcmp_channel.sv
module capcmp_channel import capcmp_pkg::*; #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ch_cfg_t          cfg,
    input  logic [CNT_W-1:0] cnt,
    input  logic             tick,
    input  logic             trig_rise,
    input  logic             trig_fall,
    input  logic             wr,
    input  logic [CNT_W-1:0] wr_val,
    output logic [CNT_W-1:0] cc,
    output logic             out,
    output logic             match
);
    typedef struct packed {
        logic [CNT_W-1:0] cc;
        logic             out;
        logic             hit;
    } ch_st_t;

    ch_st_t st_d, st_q;
    logic   cap_ev;
    logic   hit_now;

    always_comb begin
        cap_ev  = !cfg.is_cmp &&
                  ((cfg.edg[0] && trig_rise) || (cfg.edg[1] && trig_fall));
        hit_now = cfg.is_cmp && tick && (cnt == st_q.cc);
        st_d     = st_q;
        st_d.hit = hit_now;
        if (cap_ev)
            st_d.cc = cnt;
        else if (cfg.is_cmp && wr)
            st_d.cc = wr_val;
        if (hit_now)
            st_d.out = cfg.act_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cc    = st_q.cc;
    assign out   = st_q.out;
    assign match = st_q.hit;

    // R7
    out_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.hit |-> (st_q.out == $past(cfg.act_set)));
    // R5
    cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.is_cmp && !cap_ev) |=> $stable(st_q.cc));
    // R6
    cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.is_cmp && !wr) |=> $stable(st_q.cc));
endmodule

// File: rtl/capcmp_timer.sv
module capcmp_timer import capcmp_pkg::*; #(
    parameter int CNT_W       = 24,
    parameter int NCH         = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_int,
    input  logic              evt_in,
    input  logic [NCH-1:0]    trig_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_half,
    output logic [DATA_W-1:0] rd_data,
    output logic [NCH-1:0]    cmp_out,
    output logic [NCH-1:0]    match_pulse,
    output logic              ovf_pulse
);
    localparam int CFG_W = 4 * NCH;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             run;
        logic             src;
        logic             ovf;
        logic [CFG_W-1:0] cfg;
    } top_st_t;

    top_st_t          st_d, st_q;
    logic             ev_rise;
    logic             ev_fall_unused;
    logic             tick;
    logic             cnt_wr;
    logic             unused_hi;
    logic [NCH-1:0]   tr_rise, tr_fall;
    logic [CNT_W-1:0] cc_w [NCH];
    logic [DATA_W-1:0] rd_full;

    assign unused_hi = ^wr_data[DATA_W-1:CNT_W];

    capcmp_sync_edge #(.STAGES(SYNC_STAGES)) u_ev_sync (
        .clk(clk), .rst_n(rst_n), .din(evt_in),
        .rise(ev_rise), .fall(ev_fall_unused)
    );

    generate
        for (genvar n = 0; n < NCH; n++) begin : g_ch
            capcmp_sync_edge #(.STAGES(SYNC_STAGES)) u_tr_sync (
                .clk(clk), .rst_n(rst_n), .din(trig_in[n]),
                .rise(tr_rise[n]), .fall(tr_fall[n])
            );
            capcmp_channel #(.CNT_W(CNT_W)) u_ch (
                .clk(clk), .rst_n(rst_n),
                .cfg(ch_cfg_t'(st_q.cfg[4*n +: 4])),
                .cnt(st_q.cnt), .tick(tick),
                .trig_rise(tr_rise[n]), .trig_fall(tr_fall[n]),
                .wr(wr_en && (wr_addr == A_CH0 + ADDR_W'(n))),
                .wr_val(wr_data[CNT_W-1:0]),
                .cc(cc_w[n]), .out(cmp_out[n]), .match(match_pulse[n])
            );
        end
    endgenerate

    always_comb begin
        tick   = st_q.run && (st_q.src ? ev_rise : tick_int);
        cnt_wr = wr_en && (wr_addr == A_CNT);
        st_d     = st_q;
        st_d.ovf = 1'b0;
        if (cnt_wr) begin
            st_d.cnt = wr_data[CNT_W-1:0];
        end else if (tick) begin
            st_d.cnt = st_q.cnt + 1'b1;
            st_d.ovf = (st_q.cnt == CNT_MAX);
        end
        if (wr_en && wr_addr == A_CTL0) begin
            st_d.run = wr_data[0];
            st_d.src = wr_data[1];
        end
        if (wr_en && wr_addr == A_CTL1)
            st_d.cfg = wr_data[CFG_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_full = '0;
        if (rd_addr == A_CTL0) rd_full[1:0] = {st_q.src, st_q.run};
        if (rd_addr == A_CTL1) rd_full[CFG_W-1:0] = st_q.cfg;
        if (rd_addr == A_CNT)  rd_full[CNT_W-1:0] = st_q.cnt;
        for (int n = 0; n < NCH; n++)
            if (rd_addr == A_CH0 + ADDR_W'(n)) rd_full[CNT_W-1:0] = cc_w[n];
        rd_data = rd_half ? {16'h0000, rd_full[15:0]} : rd_full;
    end

    assign ovf_pulse = st_q.ovf;

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.run && !cnt_wr) |=> $stable(st_q.cnt));
    // R2
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && !st_q.src && tick_int && !cnt_wr)
        |=> (st_q.cnt == CNT_W'($past(st_q.cnt) + 1'b1)));
    // R9
    ovf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |-> (st_q.cnt == '0));
    // R4
    hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[DATA_W-1:CNT_W] == '0);
endmodule

// File: tb/tb_capcmp_timer.sv
module tb_capcmp_timer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        tick_int = 0, evt_in = 0;
    logic [3:0]  trig_in = 0;
    logic        wr_en = 0;
    logic [2:0]  wr_addr = 0, rd_addr = 0;
    logic [31:0] wr_data = 0;
    logic        rd_half = 0;
    logic [31:0] rd_data;
    logic [3:0]  cmp_out, match_pulse;
    logic        ovf_pulse;

    int checks = 0, errs = 0;
    bit ev_mode = 0;
    bit done = 0;

    capcmp_timer dut (
        .clk(clk), .rst_n(rst_n), .tick_int(tick_int), .evt_in(evt_in),
        .trig_in(trig_in), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_half(rd_half), .rd_data(rd_data),
        .cmp_out(cmp_out), .match_pulse(match_pulse), .ovf_pulse(ovf_pulse)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference
    logic [23:0] m_cnt, n_cnt;
    logic        m_run, m_src, m_ovf, n_ovf;
    logic [15:0] m_cfg;
    logic [23:0] m_cc [4];
    logic [23:0] n_cc [4];
    logic [3:0]  m_out, m_hit, n_out, n_hit;
    logic [2:0]  m_ev;
    logic [2:0]  m_tr [4];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_run = 0; m_src = 0; m_ovf = 0; m_cfg = 0;
            m_out = 0; m_hit = 0; m_ev = 0;
            for (int n = 0; n < 4; n++) begin m_cc[n] = 0; m_tr[n] = 0; end
        end else begin
            logic tk;
            tk = m_run && (m_src ? (m_ev[1] && !m_ev[2]) : tick_int);
            n_out = m_out; n_hit = 0;
            for (int n = 0; n < 4; n++) begin
                logic [3:0] c;
                logic r, f;
                c = m_cfg[4*n +: 4];
                r = m_tr[n][1] && !m_tr[n][2];
                f = !m_tr[n][1] && m_tr[n][2];
                n_cc[n] = m_cc[n];
                if (!c[0]) begin
                    if ((c[1] && r) || (c[2] && f)) n_cc[n] = m_cnt;
                end else begin
                    if (tk && m_cnt == m_cc[n]) begin n_hit[n] = 1; n_out[n] = c[3]; end
                    if (wr_en && wr_addr == 3'(4 + n)) n_cc[n] = wr_data[23:0];
                end
            end
            n_cnt = m_cnt; n_ovf = 0;
            if (wr_en && wr_addr == 3'd2) n_cnt = wr_data[23:0];
            else if (tk) begin n_ovf = (m_cnt == 24'hFFFFFF); n_cnt = m_cnt + 24'd1; end
            if (wr_en && wr_addr == 3'd0) begin m_run = wr_data[0]; m_src = wr_data[1]; end
            if (wr_en && wr_addr == 3'd1) m_cfg = wr_data[15:0];
            m_cnt = n_cnt; m_ovf = n_ovf; m_out = n_out; m_hit = n_hit;
            for (int n = 0; n < 4; n++) begin
                m_cc[n] = n_cc[n];
                m_tr[n] = {m_tr[n][1:0], trig_in[n]};
            end
            m_ev = {m_ev[1:0], evt_in};
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_rd();
        logic [31:0] v;
        v = 0;
        case (rd_addr)
            3'd0: v = {30'd0, m_src, m_run};
            3'd1: v = {16'd0, m_cfg};
            3'd2: v = {8'd0, m_cnt};
            3'd4, 3'd5, 3'd6, 3'd7: v = {8'd0, m_cc[rd_addr - 3'd4]};
            default: v = 0;
        endcase
        if (rd_half) v = {16'd0, v[15:0]};
        return v;
    endfunction

    always @(negedge clk) begin
        if (rst_n && !done) begin
            string t;
            if (rd_half) t = "R4";
            else if (rd_addr == 3'd2) t = "R2 R3 R10";
            else if (rd_addr >= 3'd4) t = "R5 R6";
            else t = "R2";
            chk(t, rd_data, exp_rd());
            chk("R7", {28'd0, cmp_out}, {28'd0, m_out});
            chk("R8", {28'd0, match_pulse}, {28'd0, m_hit});
            chk("R9", {31'd0, ovf_pulse}, {31'd0, m_ovf});
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            wr_en = 0;
            tick_int = 1'($urandom);
            rd_addr = 3'($urandom);
            rd_half = (($urandom % 4) == 0);
            if (($urandom % 3) == 0) trig_in = trig_in ^ 4'(1 << ($urandom % 4));
            if (ev_mode && (($urandom % 2) == 0)) evt_in = ~evt_in;
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        wr_en = 1; wr_addr = a; wr_data = d;
        tick_int = 1'($urandom);
        @(posedge clk); #1;
        wr_en = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errs++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1: everything reads zero after reset
        for (int a = 0; a < 8; a++) begin
            rd_addr = 3'(a); rd_half = 0;
            @(negedge clk);
            chk("R1", rd_data, 32'd0);
        end
        chk("R1", {23'd0, cmp_out, match_pulse, ovf_pulse}, 32'd0);
        // ch0/ch1 compare+set, ch2 capture rising, ch3 capture both
        wr(3'd1, 32'h0000_6299);
        wr(3'd4, 32'hAB00_0005);   // R6 upper bits dropped
        wr(3'd5, 32'h0000_0003);
        wr(3'd6, 32'h0000_0123);   // R6 ignored in capture mode
        wr(3'd0, 32'h1);
        step(60);
        wr(3'd1, 32'h0000_6219);   // ch1 compare, clear on match
        wr(3'd5, 32'h0000_0030);
        wr(3'd1, 32'h0000_6419);   // ch2 falling edge
        step(80);
        wr(3'd0, 32'h0);           // stop: counter holds
        step(30);
        wr(3'd2, 32'hFFFF_FFFC);   // R10 load near wrap
        wr(3'd4, 32'h00FF_FFFE);
        wr(3'd0, 32'h1);
        step(20);
        wr(3'd2, 32'h0000_0100);   // R10 load while running
        step(10);
        ev_mode = 1;
        wr(3'd0, 32'h3);           // R3 external source
        wr(3'd4, 32'h0000_0110);
        step(200);
        wr(3'd1, 32'h0000_0000);   // everything capture, edges off
        step(30);
        done = 1;
        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule